// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block decides, for an in-order five-stage integer pipeline, when the instruction sitting in decode must wait and where each of its two ALU operands should come from once it reaches execute. It looks at the two source register numbers of the decoding instruction and at the destination, write flag and load flag of the two older instructions now in execute and memory. From these it raises a stall request at once and, one clock later, presents a 2-bit source select for each execute-stage operand.

A static two-bit mode picks the bypass network the surrounding datapath actually has: no bypass at all, a full bypass from both pipeline registers, a bypass only from the execute/memory register, or a bypass only from the memory/writeback register. The stall rules follow from what the chosen network can deliver, so the same controller serves all four datapath variants. The register file is assumed to write early in a cycle and read late, so a producer that has reached writeback is already visible to decode.

Top module: `hzc_bypass_ctrl`

## Requirements
- R1: With mode 0 (no bypass), a source that matches the destination of the instruction in execute stalls decode for 2 cycles, and one that matches only the instruction in memory stalls for 1 cycle; when both occur the total is 2 cycles.
- R2: With mode 1 (full bypass), the only stall is a load in execute whose destination a decode source needs, which costs 1 cycle; every other dependence is bypassed with no stall.
- R3: With mode 2 (bypass from the execute/memory register only), an ALU result needed by the next instruction is bypassed with no stall, a load result needed by the next instruction costs 2 stall cycles, and a dependence on the instruction two ahead costs 1 stall cycle.
- R4: With mode 3 (bypass from the memory/writeback register only), a dependence on the instruction two ahead is bypassed with no stall, and a dependence on the next-older instruction, ALU or load, costs 1 stall cycle.
- R5: A producer three or more instructions older than the consumer never causes a stall or a bypass.
- R6: Write-after-read and write-after-write pairs never cause a stall.
- R7: Register 0 and producers whose write flag is low never create a dependence, a stall or a bypass.
- R8: Each operand select is 00 (register file), 10 (execute/memory register) or 01 (memory/writeback register); 11 is never produced, and only codes the mode's network has appear (mode 0: 00; mode 2: 00 or 10; mode 3: 00 or 01).
- R9: When both older instructions write the needed register, the younger one (in execute) is the one bypassed, and the shadowed older result causes no stall.
- R10: The selects for an instruction appear on the clock edge that moves it from decode to execute; on an edge taken while stall is high they become 00 (a bubble), repeated every stalled cycle.
- R11: While reset is high both selects are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Bypass network: 0 none, 1 full, 2 execute/memory only, 3 memory/writeback only |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| stall | output | 1 | Hold PC and decode, inject a bubble into execute |
| fwd_a | output | 2 | Source select for the first execute operand |
| fwd_b | output | 2 | Source select for the second execute operand |

## Verification
The stall request is a same-cycle function of the decode and older-stage fields, so the bench drives those fields just after a falling edge and reads stall one nanosecond later in that same cycle. The operand selects are registered and refer to whatever instruction entered execute on the last rising edge, so the bench reads them after the following falling edge and applies them to the instruction its own pipeline model has just moved into execute. Every scripted sequence is run through that cycle-accurate model, which computes each instruction's result from the selected operand sources and compares it against in-order execution, while the counted stall cycles are compared with the hand-derived totals for each mode.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

   // Bypass network available in the surrounding datapath.
   typedef enum logic [1:0] {
      BYP_NONE = 2'd0,
      BYP_FULL = 2'd1,
      BYP_NEXT = 2'd2,
      BYP_TWO  = 2'd3
   } byp_mode_e;

   // Operand source codes seen by the execute-stage multiplexer.
   localparam int          SEL_W   = 2;
   localparam logic [1:0]  SEL_RF  = 2'b00;
   localparam logic [1:0]  SEL_EXM = 2'b10;
   localparam logic [1:0]  SEL_MWB = 2'b01;

   // Number of register sources per instruction.
   localparam int          NUM_SRC = 2;

endpackage

// File: rtl/hzc_policy.sv
// Translates the bypass mode into which pipeline registers may feed execute.
module hzc_policy
   import hzc_pkg::*;
(
   input  byp_mode_e mode,
   output logic      exm_en,
   output logic      mwb_en
);

   always_comb begin
      exm_en = 1'b0;
      mwb_en = 1'b0;
      unique case (mode)
         BYP_NONE: begin exm_en = 1'b0; mwb_en = 1'b0; end
         BYP_FULL: begin exm_en = 1'b1; mwb_en = 1'b1; end
         BYP_NEXT: begin exm_en = 1'b1; mwb_en = 1'b0; end
         BYP_TWO:  begin exm_en = 1'b0; mwb_en = 1'b1; end
         default:  begin exm_en = 1'b0; mwb_en = 1'b0; end
      endcase
   end

endmodule

// File: rtl/hzc_src_eval.sv
// Dependence check for one source register of the decode instruction.
module hzc_src_eval
   import hzc_pkg::*;
#(
   parameter int REG_W = 5
)(
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             exm_en,
   input  logic             mwb_en,
   output logic             hazard,
   output logic [SEL_W-1:0] sel
);

   localparam logic [REG_W-1:0] ZERO_REG = '0;

   logic src_live;
   logic ex_hit;
   logic mem_hit;
   logic ex_ok;
   logic mem_ok;

   assign src_live = (src != ZERO_REG);

   // Distance one: producer is in execute now, in memory when we reach execute.
   assign ex_hit  = src_live && ex_wen && (ex_rd == src);
   // Distance two: shadowed by a younger writer of the same register.
   assign mem_hit = src_live && mem_wen && (mem_rd == src) && !ex_hit;

   // A load result is not ready in the execute/memory register.
   assign ex_ok   = ex_hit && exm_en && !ex_load;
   assign mem_ok  = mem_hit && mwb_en;

   assign hazard  = (ex_hit && !ex_ok) || (mem_hit && !mem_ok);

   always_comb begin
      if (ex_ok)       sel = SEL_EXM;
      else if (mem_ok) sel = SEL_MWB;
      else             sel = SEL_RF;
   end

endmodule

// File: rtl/hzc_sel_stage.sv
// Execute-stage copy of an operand select; a stall loads a bubble.
module hzc_sel_stage
   import hzc_pkg::*;
#(
   parameter int W = SEL_W
)(
   input  logic         clk,
   input  logic         rst,
   input  logic         bubble,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)         q <= '0;
      else if (bubble) q <= '0;
      else             q <= d;
   end

endmodule

// File: rtl/hzc_bypass_ctrl.sv
module hzc_bypass_ctrl
   import hzc_pkg::*;
#(
   parameter int REG_W = 5
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode,
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   output logic             stall,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b
);

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_width
         $error("hzc_bypass_ctrl: REG_W out of range");
      end
   endgenerate

   byp_mode_e mode_e;
   logic      exm_en;
   logic      mwb_en;

   assign mode_e = byp_mode_e'(mode);

   hzc_policy u_policy (
      .mode   (mode_e),
      .exm_en (exm_en),
      .mwb_en (mwb_en)
   );

   logic [REG_W-1:0] src   [NUM_SRC];
   logic [SEL_W-1:0] sel_d [NUM_SRC];
   logic [SEL_W-1:0] sel_q [NUM_SRC];
   logic [NUM_SRC-1:0] haz;

   assign src[0] = id_rs1;
   assign src[1] = id_rs2;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      hzc_src_eval #(.REG_W(REG_W)) u_eval (
         .src     (src[g]),
         .ex_rd   (ex_rd),
         .ex_wen  (ex_wen),
         .ex_load (ex_load),
         .mem_rd  (mem_rd),
         .mem_wen (mem_wen),
         .exm_en  (exm_en),
         .mwb_en  (mwb_en),
         .hazard  (haz[g]),
         .sel     (sel_d[g])
      );

      hzc_sel_stage #(.W(SEL_W)) u_stage (
         .clk    (clk),
         .rst    (rst),
         .bubble (stall),
         .d      (sel_d[g]),
         .q      (sel_q[g])
      );
   end

   assign stall = |haz;
   assign fwd_a = sel_q[0];
   assign fwd_b = sel_q[1];

endmodule

// File: rtl/hzc_bypass_ctrl_chk.sv
module hzc_bypass_ctrl_chk #(
   parameter int REG_W = 5
)(
   input logic             clk,
   input logic             rst,
   input logic [1:0]       mode,
   input logic [REG_W-1:0] id_rs1,
   input logic [REG_W-1:0] id_rs2,
   input logic [REG_W-1:0] ex_rd,
   input logic             ex_wen,
   input logic             ex_load,
   input logic [REG_W-1:0] mem_rd,
   input logic             mem_wen,
   input logic             stall,
   input logic [1:0]       fwd_a,
   input logic [1:0]       fwd_b
);

   logic ex_match;
   logic mem_match;
   logic a_legal;
   logic b_legal;

   assign ex_match  = ex_wen && (ex_rd != '0) &&
                      ((ex_rd == id_rs1) || (ex_rd == id_rs2));
   assign mem_match = mem_wen && (mem_rd != '0) &&
                      ((mem_rd == id_rs1) || (mem_rd == id_rs2));

   assign a_legal = (fwd_a == 2'b00) ||
                    (fwd_a == 2'b10 && (mode == 2'd1 || mode == 2'd2)) ||
                    (fwd_a == 2'b01 && (mode == 2'd1 || mode == 2'd3));
   assign b_legal = (fwd_b == 2'b00) ||
                    (fwd_b == 2'b10 && (mode == 2'd1 || mode == 2'd2)) ||
                    (fwd_b == 2'b01 && (mode == 2'd1 || mode == 2'd3));

   p_none_stall_r1: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd0 && (ex_match || mem_match)) |-> stall);

   p_full_only_load_r2: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd1 && stall) |-> (ex_match && ex_load));

   p_next_load_r3: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd2 && ex_match && ex_load) |-> stall);

   p_two_near_r4: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd3 && ex_match) |-> stall);

   p_zero_src_r7: assert property (@(posedge clk) disable iff (rst)
      (!stall && id_rs1 == '0 && id_rs2 == '0) |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

   p_enc_legal_r8: assert property (@(posedge clk) disable iff (rst)
      a_legal && b_legal);

   p_young_first_r9: assert property (@(posedge clk) disable iff (rst)
      (mode == 2'd1 && !stall && ex_wen && !ex_load && ex_rd != '0 && ex_rd == id_rs1)
      |=> (fwd_a == 2'b10));

   p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
      stall |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

   p_reset_r11: assert property (@(posedge clk)
      rst |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

endmodule

bind hzc_bypass_ctrl hzc_bypass_ctrl_chk #(.REG_W(REG_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .mode    (mode),
   .id_rs1  (id_rs1),
   .id_rs2  (id_rs2),
   .ex_rd   (ex_rd),
   .ex_wen  (ex_wen),
   .ex_load (ex_load),
   .mem_rd  (mem_rd),
   .mem_wen (mem_wen),
   .stall   (stall),
   .fwd_a   (fwd_a),
   .fwd_b   (fwd_b)
);

// File: tb/hzc_bypass_ctrl_bench.sv
`timescale 1ns/1ps
module hzc_bypass_ctrl_bench;

   localparam int RW   = 5;
   localparam int NREG = 32;
   localparam int NI   = 4;
   localparam int NC   = 30;

   typedef logic [17:0] ins_t;   // [17] valid [16] wen [15] load [14:10] rd [9:5] rs1 [4:0] rs2

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    mode;
   logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
   logic          ex_wen, ex_load, mem_wen;
   logic          stall;
   logic [1:0]    fwd_a, fwd_b;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   hzc_bypass_ctrl #(.REG_W(RW)) u_hzc_bypass_ctrl (
      .clk(clk), .rst(rst), .mode(mode),
      .id_rs1(id_rs1), .id_rs2(id_rs2),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
      .mem_rd(mem_rd), .mem_wen(mem_wen),
      .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
   );

   function automatic ins_t alu(input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2);
      return {1'b1, 1'b1, 1'b0, rd, s1, s2};
   endfunction
   function automatic ins_t ldw(input logic [4:0] rd, input logic [4:0] s1);
      return {1'b1, 1'b1, 1'b1, rd, s1, 5'd0};
   endfunction
   function automatic ins_t nwr(input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2);
      return {1'b1, 1'b0, 1'b0, rd, s1, s2};
   endfunction
   function automatic logic [81:0] ent(input logic [3:0] tag, input logic [1:0] m, input logic [3:0] e,
                                       input ins_t i0, input ins_t i1, input ins_t i2, input ins_t i3);
      return {tag, m, e, i0, i1, i2, i3};
   endfunction

   // Entry: requirement tag, mode, expected stall cycles, four instructions.
   localparam logic [81:0] CASES [NC] = '{
      // A: chained ALU dependences, R1 R2 R3 R4
      ent(4'd1, 2'd0, 4'd4, alu(5'd1,5'd2,5'd3), alu(5'd2,5'd1,5'd4), alu(5'd1,5'd1,5'd2), alu(5'd20,5'd21,5'd22)),
      ent(4'd2, 2'd1, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd2,5'd1,5'd4), alu(5'd1,5'd1,5'd2), alu(5'd20,5'd21,5'd22)),
      ent(4'd3, 2'd2, 4'd2, alu(5'd1,5'd2,5'd3), alu(5'd2,5'd1,5'd4), alu(5'd1,5'd1,5'd2), alu(5'd20,5'd21,5'd22)),
      ent(4'd4, 2'd3, 4'd2, alu(5'd1,5'd2,5'd3), alu(5'd2,5'd1,5'd4), alu(5'd1,5'd1,5'd2), alu(5'd20,5'd21,5'd22)),
      // B: load used by the next instruction
      ent(4'd1, 2'd0, 4'd2, ldw(5'd1,5'd2), alu(5'd3,5'd1,5'd4), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd2, 2'd1, 4'd1, ldw(5'd1,5'd2), alu(5'd3,5'd1,5'd4), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd3, 2'd2, 4'd2, ldw(5'd1,5'd2), alu(5'd3,5'd1,5'd4), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd4, 2'd3, 4'd1, ldw(5'd1,5'd2), alu(5'd3,5'd1,5'd4), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      // C: ALU result used two instructions later
      ent(4'd1, 2'd0, 4'd1, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd1,5'd8), alu(5'd20,5'd21,5'd22)),
      ent(4'd2, 2'd1, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd1,5'd8), alu(5'd20,5'd21,5'd22)),
      ent(4'd3, 2'd2, 4'd1, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd1,5'd8), alu(5'd20,5'd21,5'd22)),
      ent(4'd4, 2'd3, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd1,5'd8), alu(5'd20,5'd21,5'd22)),
      // D: load result used two instructions later on the second operand
      ent(4'd1, 2'd0, 4'd1, ldw(5'd1,5'd2), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd8,5'd1), alu(5'd20,5'd21,5'd22)),
      ent(4'd2, 2'd1, 4'd0, ldw(5'd1,5'd2), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd8,5'd1), alu(5'd20,5'd21,5'd22)),
      ent(4'd3, 2'd2, 4'd1, ldw(5'd1,5'd2), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd8,5'd1), alu(5'd20,5'd21,5'd22)),
      ent(4'd4, 2'd3, 4'd0, ldw(5'd1,5'd2), alu(5'd4,5'd5,5'd6), alu(5'd7,5'd8,5'd1), alu(5'd20,5'd21,5'd22)),
      // H: two writers of r1, R9 younger wins
      ent(4'd9, 2'd0, 4'd2, alu(5'd1,5'd2,5'd3), alu(5'd1,5'd4,5'd5), alu(5'd6,5'd1,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd9, 2'd1, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd1,5'd4,5'd5), alu(5'd6,5'd1,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd9, 2'd2, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd1,5'd4,5'd5), alu(5'd6,5'd1,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd9, 2'd3, 4'd1, alu(5'd1,5'd2,5'd3), alu(5'd1,5'd4,5'd5), alu(5'd6,5'd1,5'd7), alu(5'd20,5'd21,5'd22)),
      // J: both operands need the same producer
      ent(4'd1, 2'd0, 4'd2, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd1,5'd1), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd2, 2'd1, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd1,5'd1), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd3, 2'd2, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd1,5'd1), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd4, 2'd3, 4'd1, alu(5'd1,5'd2,5'd3), alu(5'd4,5'd1,5'd1), alu(5'd5,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      // E: register 0 as destination and source, R7
      ent(4'd7, 2'd0, 4'd0, alu(5'd0,5'd2,5'd3), alu(5'd4,5'd0,5'd0), alu(5'd5,5'd0,5'd6), alu(5'd20,5'd21,5'd22)),
      ent(4'd7, 2'd2, 4'd0, alu(5'd0,5'd2,5'd3), alu(5'd4,5'd0,5'd0), alu(5'd5,5'd0,5'd6), alu(5'd20,5'd21,5'd22)),
      // F: producer with write flag low, R7
      ent(4'd7, 2'd0, 4'd0, nwr(5'd1,5'd2,5'd3), alu(5'd4,5'd1,5'd1), alu(5'd5,5'd1,5'd6), alu(5'd20,5'd21,5'd22)),
      // G: write-after-read and write-after-write only, R6
      ent(4'd6, 2'd0, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd2,5'd4,5'd5), alu(5'd1,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      ent(4'd6, 2'd3, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd2,5'd4,5'd5), alu(5'd1,5'd6,5'd7), alu(5'd20,5'd21,5'd22)),
      // I: producer three instructions back, R5
      ent(4'd5, 2'd0, 4'd0, alu(5'd1,5'd2,5'd3), alu(5'd20,5'd21,5'd22), alu(5'd23,5'd24,5'd25), alu(5'd9,5'd1,5'd1))
   };

   function automatic logic [31:0] calc(input ins_t i, input int k, input logic [31:0] a, input logic [31:0] b);
      if (i[15]) return a ^ 32'h00A5_5A00;
      return a + b + 32'(k + 1);
   endfunction

   function automatic bit legal(input logic [1:0] m, input logic [1:0] s);
      case (s)
         2'b00:   return 1'b1;
         2'b10:   return (m == 2'd1) || (m == 2'd2);
         2'b01:   return (m == 2'd1) || (m == 2'd3);
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      id_rs1 = '0; id_rs2 = '0; ex_rd = '0; ex_wen = 1'b0; ex_load = 1'b0;
      mem_rd = '0; mem_wen = 1'b0;
   endtask

   task automatic run_case(input int cn, input logic [81:0] e);
      ins_t        prog [NI];
      logic [31:0] gold [NI];
      logic [31:0] g    [NREG];
      logic [31:0] rf   [NREG];
      string       req;
      int          pc = 0, got = 0, stalls = 0, cyc = 0, illegal = 0;
      bit          id_v = 0, ex_v = 0, mem_v = 0, wb_v = 0;
      ins_t        id_i = '0, ex_i = '0, mem_i = '0, wb_i = '0;
      int          id_n = 0, ex_n = 0;
      logic [31:0] ex_a = '0, ex_b = '0, mem_r = '0, wb_r = '0, opa, opb, res = '0;

      req  = $sformatf("R%0d", e[81:78]);
      mode = e[77:76];
      prog[0] = e[71:54]; prog[1] = e[53:36]; prog[2] = e[35:18]; prog[3] = e[17:0];
      for (int r = 0; r < NREG; r++) begin
         g[r]  = (r == 0) ? 32'd0 : 32'(r * 256 + 7);
         rf[r] = g[r];
      end
      // In-order reference results.
      for (int k = 0; k < NI; k++) begin
         gold[k] = calc(prog[k], k, g[prog[k][9:5]], g[prog[k][4:0]]);
         if (prog[k][16] && prog[k][14:10] != 5'd0) g[prog[k][14:10]] = gold[k];
      end

      while (got < NI && cyc < 60) begin
         if (wb_v && wb_i[16] && wb_i[14:10] != 5'd0) rf[wb_i[14:10]] = wb_r;
         id_rs1  = id_v ? id_i[9:5] : '0;
         id_rs2  = id_v ? id_i[4:0] : '0;
         ex_rd   = ex_v ? ex_i[14:10] : '0;
         ex_wen  = ex_v && ex_i[16];
         ex_load = ex_v && ex_i[15];
         mem_rd  = mem_v ? mem_i[14:10] : '0;
         mem_wen = mem_v && mem_i[16];
         #1;
         if (!legal(mode, fwd_a) || !legal(mode, fwd_b)) illegal++;
         if (ex_v) begin
            opa = (fwd_a == 2'b10) ? mem_r : (fwd_a == 2'b01) ? wb_r : ex_a;
            opb = (fwd_b == 2'b10) ? mem_r : (fwd_b == 2'b01) ? wb_r : ex_b;
            res = calc(ex_i, ex_n, opa, opb);
            check(res === gold[ex_n], req, $sformatf("case %0d instr %0d operand result", cn, ex_n),
                  res, gold[ex_n]);
            got++;
         end
         if (stall) stalls++;
         wb_v  = mem_v; wb_i  = mem_i; wb_r  = mem_r;
         mem_v = ex_v;  mem_i = ex_i;  mem_r = res;
         if (stall) begin
            ex_v = 1'b0;
         end else begin
            ex_v = id_v; ex_i = id_i; ex_n = id_n;
            ex_a = rf[id_i[9:5]]; ex_b = rf[id_i[4:0]];
            if (pc < NI) begin
               id_v = 1'b1; id_i = prog[pc]; id_n = pc; pc++;
            end else begin
               id_v = 1'b0;
            end
         end
         cyc++;
         @(posedge clk);
         @(negedge clk);
      end
      check(got == NI, req, $sformatf("case %0d completed instructions", cn), 32'(got), 32'(NI));
      check(stalls == int'(e[75:72]), req, $sformatf("case %0d stall cycles", cn),
            32'(stalls), 32'(e[75:72]));
      check(illegal == 0, "R8", $sformatf("case %0d illegal select cycles", cn), 32'(illegal), 32'd0);
      idle_inputs();
      repeat (2) begin @(posedge clk); @(negedge clk); end
   endtask

   initial begin
      #(2_000_000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog run not complete actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; mode = 2'd1;
      idle_inputs();
      // Reset dominates a pending bypass (R11).
      id_rs1 = 5'd5; id_rs2 = 5'd5; ex_rd = 5'd5; ex_wen = 1'b1;
      @(posedge clk); @(negedge clk); #1;
      check(fwd_a == 2'b00 && fwd_b == 2'b00, "R11", "selects in reset", {fwd_a, fwd_b}, 32'd0);
      check(stall == 1'b0, "R2", "ALU dependence in full mode stall", stall, 0);
      rst = 1'b0;
      check(fwd_a == 2'b00, "R10", "select before decode edge", fwd_a, 32'd0);
      @(posedge clk); @(negedge clk); #1;
      check(fwd_a == 2'b10 && fwd_b == 2'b10, "R10", "both selects after edge", {fwd_a, fwd_b}, 32'hA);
      // Load in execute: stall and a bubble on the next edge (R2, R10).
      ex_load = 1'b1; #1;
      check(stall == 1'b1, "R2", "load next-use stall", stall, 1);
      @(posedge clk); @(negedge clk); #1;
      check(fwd_a == 2'b00 && fwd_b == 2'b00, "R10", "bubble after stalled edge", {fwd_a, fwd_b}, 32'd0);
      // Register 0 never matches (R7).
      mode = 2'd0; id_rs1 = 5'd0; id_rs2 = 5'd0; ex_rd = 5'd0; ex_wen = 1'b1; ex_load = 1'b0; #1;
      check(stall == 1'b0, "R7", "register 0 dependence", stall, 0);
      idle_inputs();
      @(posedge clk); @(negedge clk);

      for (int c = 0; c < NC; c++) run_case(c, CASES[c]);

      // Separate sources from the two pipeline registers, then a shared target (R9).
      mode = 2'd1; id_rs1 = 5'd7; id_rs2 = 5'd9;
      ex_rd = 5'd7; ex_wen = 1'b1; mem_rd = 5'd9; mem_wen = 1'b1; #1;
      check(stall == 1'b0, "R2", "full mode mixed sources stall", stall, 0);
      @(posedge clk); @(negedge clk); #1;
      check(fwd_a == 2'b10 && fwd_b == 2'b01, "R8", "distinct source codes", {fwd_a, fwd_b}, 32'h9);
      mem_rd = 5'd7; id_rs2 = 5'd0;
      @(posedge clk); @(negedge clk); #1;
      check(fwd_a == 2'b10, "R9", "younger producer chosen", fwd_a, 32'h2);
      mode = 2'd2; #1;
      check(stall == 1'b0, "R9", "shadowed older writer stall", stall, 0);
      idle_inputs();
      @(posedge clk); @(negedge clk);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule